// File: doc/BRIEF.md
# Stochastic Masked Hidden-Weight Updater

This block holds a bank of high-precision hidden weights for on-chip learning. Each weight is a sign-magnitude integer. An update request carries a weight index and a signed step in the same format. The step is added to the selected weight only when a pseudo-random mask bit for that request is set. The chance that the mask bit is set is set by a programmable 8-bit threshold. The sum saturates instead of wrapping. No momentum or carried state exists between requests.

A separate strobe marks the end of each training sample. The block counts these strobes and raises a sticky flag once every `xfer_interval` samples, which tells the surrounding logic that the low-precision copies should now be refreshed. For that refresh, a read port returns any selected weight cut down to its sign and its three most significant magnitude bits, which gives an integer in the range -7 to +7.

Top module: `hw_masked_updater`

## Requirements
- R1: After a synchronous active-low reset, every weight holds +0 (sign 0, magnitude 0), `xfer_due` is low and the mask generator holds its seed value.
- R2: A weight and `upd_delta` share one format: bit 9 is the sign (1 = negative) and bits 8:0 are the magnitude.
- R3: When the weight and the applied step have the same sign, the magnitudes are added and the sign is kept. A sum above 511 saturates at 511.
- R4: When the signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. A zero result is always stored as +0, including the cases of a -0 step and an exact cancellation.
- R5: The mask generator is a 16-bit Fibonacci LFSR that shifts left and feeds in bits 15^13^12^10. It is seeded with 16'hACE1 and advances only on cycles where `upd_valid` is high. A request is applied at that clock edge only if the LFSR's low byte, taken before the advance, is strictly less than `mask_thr`. A threshold of 0 therefore never applies a step.
- R6: An applied update changes only the weight addressed by `upd_idx`. All other weights keep their values.
- R7: Each `sample_done` pulse advances a sample counter. On the pulse that brings the count to `xfer_interval`, `xfer_due` is set from the next cycle and the counter returns to zero. An interval of 0 or 1 sets the flag on every pulse.
- R8: `xfer_due` stays high until `xfer_ack` is seen and is cleared by it. If an acknowledge and a new setting pulse arrive in the same cycle, the flag stays set.
- R9: `lp_sign` and `lp_mag` show, without a clock delay, the sign bit and magnitude bits 8:6 of the weight selected by `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_valid | input | 1 | Update request strobe |
| upd_idx | input | 4 | Index of the weight to update |
| upd_delta | input | 10 | Signed step, sign-magnitude |
| mask_thr | input | 8 | Mask probability threshold (hit if LFSR byte < threshold) |
| sample_done | input | 1 | End-of-sample strobe |
| xfer_interval | input | 16 | Samples between transfers (k) |
| xfer_ack | input | 1 | Clears the transfer-due flag |
| xfer_due | output | 1 | Transfer of low-precision weights is due |
| rd_idx | input | 4 | Index of the weight to read out |
| lp_sign | output | 1 | Sign of the selected weight |
| lp_mag | output | 3 | Top three magnitude bits of the selected weight |

## Verification
The hardest conditions to reach from the ports are a saturated weight and an exact cancellation to +0. This is because the random mask may skip any given step, so the bench cannot know ahead of time that a step has landed. The bench therefore keeps its own copy of the LFSR and computes every mask decision itself. It drives long runs of same-sign full-scale steps with a near-certain threshold to push one weight into saturation, and it drives an opposing pair of equal steps to a fresh weight to make it cancel. These directed cases are mixed with seeded random requests. A threshold of zero shows that a skipped request still advances the mask sequence.

// File: rtl/hw_upd_pkg.sv
// Shared widths and the hidden-weight word type.
// Assumes sign-magnitude storage, with the sign in the top bit.
package hw_upd_pkg;
    localparam int HW_MAG_W  = 9;
    localparam int HW_MSB_W  = 3;
    localparam int HW_THR_W  = 8;
    localparam int HW_LFSR_W = 16;

    typedef struct packed {
        logic                sgn;
        logic [HW_MAG_W-1:0] mag;
    } hw_word_t;
endpackage

// File: rtl/hw_lfsr_mask.sv
// Pseudo-random mask source: a left-shifting Fibonacci LFSR whose low
// THR_W bits are compared with a threshold to make one mask bit per step.
// Assumes SEED is nonzero and TAPS gives a maximal-length sequence.
module hw_lfsr_mask #(
    parameter int             LFSR_W = 16,
    parameter int             THR_W  = 8,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [THR_W-1:0] thr,
    output logic             hit
);
    logic [LFSR_W-1:0] lfsr_q;
    logic              fb;

    // Feedback bit: parity of the tapped bits.
    assign fb  = ^(lfsr_q & TAPS);
    // Mask decision from the state before the advance.
    assign hit = (lfsr_q[THR_W-1:0] < thr);

    // Advance the sequence once per consumed draw.
    always_ff @(posedge clk) begin
        if (!rst_n)      lfsr_q <= SEED;
        else if (step)   lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
    end

    // R5
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
    // R5
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(lfsr_q));
endmodule

// File: rtl/hw_sm_adder.sv
// Combinational sign-magnitude adder with saturation at the largest
// magnitude and a zero result forced to positive sign.
module hw_sm_adder #(
    parameter int MAG_W = 9
) (
    input  logic             a_sgn,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_sgn,
    input  logic [MAG_W-1:0] b_mag,
    output logic             r_sgn,
    output logic [MAG_W-1:0] r_mag
);
    localparam logic [MAG_W-1:0] MAG_MAX = '1;

    logic [MAG_W:0]   sum_w;
    logic [MAG_W-1:0] mag_c;
    logic             sgn_c;

    assign sum_w = {1'b0, a_mag} + {1'b0, b_mag};

    // Choose add or subtract by sign agreement, then saturate.
    always_comb begin
        if (a_sgn == b_sgn) begin
            mag_c = sum_w[MAG_W] ? MAG_MAX : sum_w[MAG_W-1:0];
            sgn_c = a_sgn;
        end else if (a_mag >= b_mag) begin
            mag_c = a_mag - b_mag;
            sgn_c = a_sgn;
        end else begin
            mag_c = b_mag - a_mag;
            sgn_c = b_sgn;
        end
    end

    // Normalise zero to positive sign.
    assign r_mag = mag_c;
    assign r_sgn = (mag_c == '0) ? 1'b0 : sgn_c;
endmodule

// File: rtl/hw_sample_counter.sv
// Counts end-of-sample strobes and raises a sticky due flag once every
// interval samples. An interval of 0 or 1 fires on every strobe.
module hw_sample_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_done,
    input  logic [CNT_W-1:0] interval,
    input  logic             ack,
    output logic             due
);
    logic [CNT_W-1:0] cnt_q;
    logic             due_q;
    logic             wrap;

    // Wrap when this strobe brings the count up to the interval.
    assign wrap = sample_done &&
                  (({1'b0, cnt_q} + 1'b1) >= {1'b0, interval});

    // Sample count, cleared on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (wrap)        cnt_q <= '0;
        else if (sample_done) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky flag: a set wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    due_q <= 1'b0;
        else if (wrap) due_q <= 1'b1;
        else if (ack)  due_q <= 1'b0;
    end

    assign due = due_q;

    // R8
    due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        due_q && !ack |=> due_q);
    // R8
    due_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !sample_done |=> !due_q);
    // R7
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_done |=> $stable(cnt_q) && $stable(due_q) || !due_q);
endmodule

// File: rtl/hw_masked_updater.sv
// Hidden-weight bank with masked sign-magnitude updates, a periodic
// transfer flag and a truncated read port. Out-of-range indices are
// ignored on update and read back as +0.
module hw_masked_updater
    import hw_upd_pkg::*;
#(
    parameter int                     NUM_W     = 16,
    parameter int                     CNT_W     = 16,
    parameter logic [HW_LFSR_W-1:0]   LFSR_SEED = 16'hACE1,
    parameter int                     IDX_W     = (NUM_W > 1) ? $clog2(NUM_W) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_valid,
    input  logic [IDX_W-1:0]     upd_idx,
    input  logic [HW_MAG_W:0]    upd_delta,
    input  logic [HW_THR_W-1:0]  mask_thr,
    input  logic                 sample_done,
    input  logic [CNT_W-1:0]     xfer_interval,
    input  logic                 xfer_ack,
    output logic                 xfer_due,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 lp_sign,
    output logic [HW_MSB_W-1:0]  lp_mag
);
    localparam int LP_W = 1 + HW_MSB_W;

    hw_word_t [NUM_W-1:0] wt_q;
    hw_word_t             old_w;
    hw_word_t             dlt_w;
    hw_word_t             new_w;
    logic                 mask_hit;
    logic                 upd_ok;
    logic                 apply;
    logic [LP_W-1:0]      lp_arr [NUM_W];
    logic [LP_W-1:0]      lp_sel;

    assign dlt_w  = hw_word_t'(upd_delta);
    assign upd_ok = (int'(upd_idx) < NUM_W);
    // Current value of the addressed weight.
    assign old_w  = upd_ok ? wt_q[upd_idx] : '0;
    assign apply  = upd_valid && upd_ok && mask_hit;

    hw_lfsr_mask #(
        .LFSR_W (HW_LFSR_W),
        .THR_W  (HW_THR_W),
        .TAPS   (16'hB400),
        .SEED   (LFSR_SEED)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (upd_valid),
        .thr   (mask_thr),
        .hit   (mask_hit)
    );

    hw_sm_adder #(.MAG_W(HW_MAG_W)) u_add (
        .a_sgn (old_w.sgn),
        .a_mag (old_w.mag),
        .b_sgn (dlt_w.sgn),
        .b_mag (dlt_w.mag),
        .r_sgn (new_w.sgn),
        .r_mag (new_w.mag)
    );

    // Weight bank: write the sum back into the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wt_q <= '0;
        end else if (apply) begin
            for (int i = 0; i < NUM_W; i++)
                if (int'(upd_idx) == i) wt_q[i] <= new_w;
        end
    end

    // Truncated view per entry, plus the no-negative-zero guard.
    for (genvar g = 0; g < NUM_W; g++) begin : g_lp
        assign lp_arr[g] = {wt_q[g].sgn, wt_q[g].mag[HW_MAG_W-1 -: HW_MSB_W]};
        // R4
        neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wt_q[g].sgn && wt_q[g].mag == '0));
    end

    // Read-port mux.
    assign lp_sel  = (int'(rd_idx) < NUM_W) ? lp_arr[rd_idx] : '0;
    assign lp_sign = lp_sel[LP_W-1];
    assign lp_mag  = lp_sel[HW_MSB_W-1:0];

    hw_sample_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_done (sample_done),
        .interval    (xfer_interval),
        .ack         (xfer_ack),
        .due         (xfer_due)
    );

    // R5
    thr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_thr == '0 |=> $stable(wt_q));
    // R3
    grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply && (old_w.sgn == dlt_w.sgn) |=>
        wt_q[$past(upd_idx)].mag >= $past(old_w.mag));
    // R6
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(wt_q));
endmodule

// File: tb/hw_masked_updater_tb_top.sv
module hw_masked_updater_tb_top;
    localparam int NW = 16;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        upd_valid = 0;
    logic [3:0]  upd_idx = 0;
    logic [9:0]  upd_delta = 0;
    logic [7:0]  mask_thr = 0;
    logic        sample_done = 0;
    logic [15:0] xfer_interval = 16'd5;
    logic        xfer_ack = 0;
    logic        xfer_due;
    logic [3:0]  rd_idx = 0;
    logic        lp_sign;
    logic [2:0]  lp_mag;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench model state
    int          m_val [NW];
    logic [15:0] m_lfsr;

    always #5 clk = ~clk;

    hw_masked_updater dut_i (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_delta(upd_delta), .mask_thr(mask_thr), .sample_done(sample_done),
        .xfer_interval(xfer_interval), .xfer_ack(xfer_ack), .xfer_due(xfer_due),
        .rd_idx(rd_idx), .lp_sign(lp_sign), .lp_mag(lp_mag)
    );

    function automatic int clamp(int v);
        if (v > 511) return 511;
        if (v < -511) return -511;
        return v;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare the read port for one weight with the model (R9).
    task automatic chk_w(string tag, int idx);
        int v;
        int ms;
        int mm;
        rd_idx = idx[3:0];
        #1;
        v  = m_val[idx];
        ms = (v < 0) ? 1 : 0;
        mm = ((v < 0) ? -v : v) >> 6;
        check({tag, " sign"}, int'(lp_sign), ms);
        check({tag, " msb"}, int'(lp_mag), mm);
    endtask

    // One update request; the model mirrors mask and sum (R2..R5).
    task automatic upd(int idx, bit s, int mag);
        upd_valid = 1;
        upd_idx   = idx[3:0];
        upd_delta = {s, mag[8:0]};
        @(posedge clk);
        if (m_lfsr[7:0] < mask_thr)
            m_val[idx] = clamp(m_val[idx] + (s ? -mag : mag));
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        @(negedge clk);
        upd_valid = 0;
    endtask

    task automatic pulse(bit sd, bit ak);
        sample_done = sd;
        xfer_ack    = ak;
        @(posedge clk);
        @(negedge clk);
        sample_done = 0;
        xfer_ack    = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NW; i++) m_val[i] = 0;
        m_lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        for (int i = 0; i < NW; i++) chk_w("R1 reset weight", i);
        check("R1 due after reset", int'(xfer_due), 0);

        // R3: same-sign growth up to saturation
        mask_thr = 8'd255;
        upd(3, 0, 100);
        chk_w("R3 add", 3);
        for (int n = 0; n < 6; n++) upd(5, 0, 400);
        chk_w("R3 saturate", 5);
        check("R3 saturated model", m_val[5], 511);

        // R4: opposite signs, cancellation and -0 step
        upd(5, 1, 511);
        chk_w("R4 subtract to zero", 5);
        upd(3, 1, 0);
        chk_w("R4 minus-zero step", 3);
        upd(7, 1, 200);
        chk_w("R4 negative", 7);
        upd(7, 0, 200);
        chk_w("R4 cancel to +0", 7);
        upd(9, 1, 64);
        upd(9, 0, 400);
        chk_w("R4 larger sign wins", 9);

        // R5: zero threshold never applies, but the sequence still advances
        mask_thr = 8'd0;
        for (int n = 0; n < 20; n++) upd(n % NW, n[0], 300);
        for (int i = 0; i < NW; i++) chk_w("R5 thr zero", i);

        // R5/R6/R9: seeded random requests and thresholds
        for (int n = 0; n < 600; n++) begin
            int idx;
            mask_thr = 8'($urandom_range(0, 255));
            idx = $urandom_range(0, NW - 1);
            upd(idx, 1'($urandom_range(0, 1)), $urandom_range(0, 511));
            chk_w("R5 random", idx);
            if (n % 50 == 49)
                for (int i = 0; i < NW; i++) chk_w("R6 others", i);
        end

        // R7: interval of five
        xfer_interval = 16'd5;
        for (int n = 0; n < 4; n++) begin
            pulse(1, 0);
            check("R7 before k", int'(xfer_due), 0);
        end
        pulse(1, 0);
        check("R7 at k", int'(xfer_due), 1);

        // R8: hold, acknowledge, set beats ack
        repeat (4) @(negedge clk);
        check("R8 hold", int'(xfer_due), 1);
        pulse(0, 1);
        check("R8 ack clears", int'(xfer_due), 0);
        for (int n = 0; n < 4; n++) pulse(1, 0);
        check("R7 second period", int'(xfer_due), 0);
        pulse(1, 1);
        check("R8 set wins", int'(xfer_due), 1);
        pulse(0, 1);
        check("R8 ack again", int'(xfer_due), 0);

        // R7: interval 0 and 1 fire every sample
        xfer_interval = 16'd1;
        pulse(1, 0);
        check("R7 k=1", int'(xfer_due), 1);
        pulse(0, 1);
        xfer_interval = 16'd0;
        pulse(1, 0);
        check("R7 k=0", int'(xfer_due), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule